// File: doc/BRIEF.md
# Divided-Clock JTAG Shift Engine

This block is the bit-level engine of a four-wire JTAG host. It drives the test clock, mode select and data-in lines of a scan chain and samples the data-out line coming back from it. A command supplies a bit count and two vectors of the same width, one holding the mode-select bits and one holding the data-in bits. The engine shifts them out least significant bit first and returns a word of the captured data-out bits.

The test clock comes from the block clock through a programmable integer divisor D, which can be set from 1 to `DIV_MAX` (3750 by default). Each clock phase lasts D cycles of the block clock, so a full TCK period is 2·D block cycles. With the block clock at twice a 30 MHz base, this covers TCK rates from 30 MHz down to 8 kHz. Mode-select and data-in bits change together with the falling TCK edge, and data-out is sampled on the rising edge.

While the engine is disabled, all three driven lines report their output enables low, so a board-level tri-state buffer can release the bus for other masters to use.

Top module: `jtag_scan_engine`

## Requirements
- R1: Each TCK phase lasts D block-clock cycles, where D is the divisor latched when the command was accepted. The first rising edge appears D cycles after acceptance. The rising edge for bit k appears (2k+1)·D cycles after acceptance. TCK is low after reset and whenever the engine is idle.
- R2: After reset, `div_active` is 4. A `div_wr` pulse whose value lies in 1..`DIV_MAX` replaces `div_active` on the next cycle. A value of 0 or above `DIV_MAX` leaves `div_active` unchanged.
- R3: A divisor write in the same cycle as a command acceptance does not affect that command, which keeps the old divisor. The new divisor applies from the next command on.
- R4: Bit k of `cmd_tms` and bit k of `cmd_tdi` drive `tms_o` and `tdi_o` from the falling edge that ends bit k-1 (bit 0 from the cycle after acceptance). They hold steady for the whole time TCK is high.
- R5: `tdo_i` is sampled at the block-clock edge where TCK rises for bit k and stored in `rsp_tdo[k]`. Bits at and above the effective length read 0.
- R6: A command of n>0 bits produces exactly n rising TCK edges. `rsp_done` pulses for one cycle, 2·n·D cycles after acceptance, with TCK low. `rsp_tdo` stays valid from that pulse until the next acceptance.
- R7: A command with `cmd_len`=0 raises `rsp_done` in the cycle after acceptance and never toggles TCK.
- R8: A `cmd_len` greater than `MAX_BITS` is shifted as `MAX_BITS` bits.
- R9: `cmd_ready` is high only while `enable` is high and no command is in progress. A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high.
- R10: `tck_oe`, `tms_oe` and `tdi_oe` are 0 after reset and follow `enable` with one cycle of delay. Dropping `enable` abandons any running command: TCK goes low and no `rsp_done` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the TCK base rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable; low releases the bus |
| div_wr | input | 1 | Divisor write strobe |
| div_val | input | DIV_W | Divisor value offered with `div_wr` |
| div_active | output | DIV_W | Divisor currently in force |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_len | input | LEN_W | Number of bits to shift |
| cmd_tms | input | MAX_BITS | Mode-select bits, bit 0 first |
| cmd_tdi | input | MAX_BITS | Data-in bits, bit 0 first |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_tdo | output | MAX_BITS | Captured data-out bits, bit 0 first |
| tck_o | output | 1 | Test clock level |
| tck_oe | output | 1 | Test clock output enable |
| tms_o | output | 1 | Mode-select level |
| tms_oe | output | 1 | Mode-select output enable |
| tdi_o | output | 1 | Data-in level |
| tdi_oe | output | 1 | Data-in output enable |
| tdo_i | input | 1 | Data-out from the chain |

## Verification
Two functions can fall in the same cycle: a divisor write and a command acceptance. The bench provokes this by raising `div_wr` together with `cmd_valid` while `cmd_ready` is high. It then measures every rising-edge position of that command against the old divisor. Finally it measures a following command against the new divisor and reads `div_active` to confirm the write was taken.

// File: rtl/jse_pkg.sv
package jse_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Clamp a requested length to the widest command the engine holds.
    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction
endpackage

// File: rtl/jse_div_reg.sv
module jse_div_reg #(
    parameter int DIV_W     = 12,
    parameter int DIV_MAX   = 3750,
    parameter int DIV_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wr_val,
    output logic [DIV_W-1:0] div_q
);
    localparam logic [DIV_W-1:0] LIM   = DIV_W'(DIV_MAX);
    localparam logic [DIV_W-1:0] RSTV  = DIV_W'(DIV_RESET);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } dreg_t;

    dreg_t r_d, r_q;
    logic  in_range;

    always_comb begin
        r_d      = r_q;
        in_range = (wr_val != '0) && (wr_val <= LIM);
        if (wr && in_range) begin
            r_d.div = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.div <= RSTV;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_q = r_q.div;
endmodule

// File: rtl/jse_phase_timer.sv
module jse_phase_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             expire
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = load_val - DIV_W'(1);
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expire = (r_q.cnt == '0);
endmodule

// File: rtl/jse_capture.sv
module jse_capture #(
    parameter int MAX_BITS = 32,
    localparam int IDX_W   = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                cap_en,
    input  logic [IDX_W-1:0]    cap_idx,
    input  logic                cap_bit,
    output logic [MAX_BITS-1:0] word
);
    typedef struct packed {
        logic [MAX_BITS-1:0] w;
    } cap_t;

    cap_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.w = '0;
        end else if (cap_en) begin
            for (int i = 0; i < MAX_BITS; i++) begin
                if (cap_idx == IDX_W'(i)) begin
                    r_d.w[i] = cap_bit;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.w <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word = r_q.w;
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
    import jse_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int DIV_W     = 12,
    parameter int DIV_MAX   = 3750,
    parameter int DIV_RESET = 4,
    localparam int LEN_W    = $clog2(MAX_BITS + 1),
    localparam int IDX_W    = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                div_wr,
    input  logic [DIV_W-1:0]    div_val,
    output logic [DIV_W-1:0]    div_active,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [MAX_BITS-1:0] cmd_tms,
    input  logic [MAX_BITS-1:0] cmd_tdi,
    output logic                rsp_done,
    output logic [MAX_BITS-1:0] rsp_tdo,
    output logic                tck_o,
    output logic                tck_oe,
    output logic                tms_o,
    output logic                tms_oe,
    output logic                tdi_o,
    output logic                tdi_oe,
    input  logic                tdo_i
);
    localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_BITS);

    typedef struct packed {
        phase_e              phase;
        logic [LEN_W-1:0]    remain;
        logic [IDX_W-1:0]    idx;
        logic [MAX_BITS-1:0] tms_sh;
        logic [MAX_BITS-1:0] tdi_sh;
        logic                tck;
        logic                done;
        logic                drv;
        logic [DIV_W-1:0]    cdiv;
    } eng_t;

    eng_t r_d, r_q;

    logic             accept;
    logic [LEN_W-1:0] eff_len;
    logic             t_load;
    logic [DIV_W-1:0] t_val;
    logic             t_expire;
    logic             c_clear;
    logic             c_en;

    // Divisor register with range filtering.
    jse_div_reg #(
        .DIV_W     (DIV_W),
        .DIV_MAX   (DIV_MAX),
        .DIV_RESET (DIV_RESET)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (div_wr),
        .wr_val (div_val),
        .div_q  (div_active)
    );

    // Half-period timer.
    jse_phase_timer #(
        .DIV_W (DIV_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    // Captured data-out packing.
    jse_capture #(
        .MAX_BITS (MAX_BITS)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (c_clear),
        .cap_en  (c_en),
        .cap_idx (r_q.idx),
        .cap_bit (tdo_i),
        .word    (rsp_tdo)
    );

    assign cmd_ready = enable && (r_q.phase == PH_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign eff_len   = (cmd_len > LEN_LIM) ? LEN_LIM : cmd_len;

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        r_d.drv  = enable;
        t_load  = 1'b0;
        t_val   = r_q.cdiv;
        c_clear = 1'b0;
        c_en    = 1'b0;

        if (!enable) begin
            r_d.phase  = PH_IDLE;
            r_d.tck    = 1'b0;
            r_d.remain = '0;
        end else begin
            unique case (r_q.phase)
                PH_IDLE: begin
                    if (accept) begin
                        c_clear    = 1'b1;
                        r_d.tms_sh = cmd_tms;
                        r_d.tdi_sh = cmd_tdi;
                        r_d.idx    = '0;
                        r_d.cdiv   = div_active;
                        if (eff_len == '0) begin
                            r_d.done = 1'b1;
                        end else begin
                            r_d.phase  = PH_LOW;
                            r_d.remain = eff_len;
                            t_load     = 1'b1;
                            t_val      = div_active;
                        end
                    end
                end
                PH_LOW: begin
                    if (t_expire) begin
                        r_d.tck   = 1'b1;
                        r_d.phase = PH_HIGH;
                        c_en      = 1'b1;
                        t_load    = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (t_expire) begin
                        r_d.tck = 1'b0;
                        t_load  = 1'b1;
                        if (r_q.remain == LEN_W'(1)) begin
                            r_d.phase  = PH_IDLE;
                            r_d.remain = '0;
                            r_d.done   = 1'b1;
                        end else begin
                            r_d.phase  = PH_LOW;
                            r_d.remain = r_q.remain - LEN_W'(1);
                            r_d.idx    = r_q.idx + IDX_W'(1);
                            r_d.tms_sh = r_q.tms_sh >> 1;
                            r_d.tdi_sh = r_q.tdi_sh >> 1;
                        end
                    end
                end
                default: begin
                    r_d.phase = PH_IDLE;
                    r_d.tck   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase  <= PH_IDLE;
            r_q.remain <= '0;
            r_q.idx    <= '0;
            r_q.tms_sh <= '0;
            r_q.tdi_sh <= '0;
            r_q.tck    <= 1'b0;
            r_q.done   <= 1'b0;
            r_q.drv    <= 1'b0;
            r_q.cdiv   <= DIV_W'(DIV_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_done = r_q.done;
    assign tck_o    = r_q.tck;
    assign tms_o    = r_q.tms_sh[0];
    assign tdi_o    = r_q.tdi_sh[0];
    assign tck_oe   = r_q.drv;
    assign tms_oe   = r_q.drv;
    assign tdi_oe   = r_q.drv;
endmodule

// File: rtl/jse_checker.sv
module jse_checker #(
    parameter int MAX_BITS = 32,
    parameter int DIV_W    = 12,
    parameter int DIV_MAX  = 3750,
    parameter int LEN_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                div_wr,
    input logic [DIV_W-1:0]    div_val,
    input logic [DIV_W-1:0]    div_active,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [LEN_W-1:0]    cmd_len,
    input logic                rsp_done,
    input logic                tck_o,
    input logic                tck_oe,
    input logic                tms_o,
    input logic                tms_oe,
    input logic                tdi_o,
    input logic                tdi_oe
);
    localparam logic [DIV_W-1:0] LIM = DIV_W'(DIV_MAX);

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_active != '0) && (div_active <= LIM)); // R2

    AST_DIV_BAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr && ((div_val == '0) || (div_val > LIM)) |=> $stable(div_active)); // R2

    AST_READY_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tck_o); // R1

    AST_LINES_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tck_o |-> ($stable(tms_o) && $stable(tdi_o))); // R4

    AST_DONE_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !tck_o); // R6

    AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_len == '0) |=> (rsp_done && !tck_o)); // R7

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !cmd_ready); // R9

    AST_RELEASE_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tck_oe && !tms_oe && !tdi_oe && !tck_o && !rsp_done)); // R10
endmodule

bind jtag_scan_engine jse_checker #(
    .MAX_BITS (MAX_BITS),
    .DIV_W    (DIV_W),
    .DIV_MAX  (DIV_MAX),
    .LEN_W    (LEN_W)
) u_jse_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .div_wr     (div_wr),
    .div_val    (div_val),
    .div_active (div_active),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_len    (cmd_len),
    .rsp_done   (rsp_done),
    .tck_o      (tck_o),
    .tck_oe     (tck_oe),
    .tms_o      (tms_o),
    .tms_oe     (tms_oe),
    .tdi_o      (tdi_o),
    .tdi_oe     (tdi_oe)
);

// File: tb/jtag_scan_engine_tb_top.sv
`timescale 1ns/1ps
module jtag_scan_engine_tb_top;
    localparam int MAXB  = 32;
    localparam int DW    = 12;
    localparam int DMAX  = 3750;
    localparam int LW    = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            div_wr = 1'b0;
    logic [DW-1:0]   div_val = '0;
    logic [DW-1:0]   div_active;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [LW-1:0]   cmd_len = '0;
    logic [MAXB-1:0] cmd_tms = '0;
    logic [MAXB-1:0] cmd_tdi = '0;
    logic            rsp_done;
    logic [MAXB-1:0] rsp_tdo;
    logic            tck_o, tck_oe, tms_o, tms_oe, tdi_o, tdi_oe;
    logic            tdo_i = 1'b1;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    jtag_scan_engine #(
        .MAX_BITS (MAXB),
        .DIV_W    (DW),
        .DIV_MAX  (DMAX),
        .DIV_RESET(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .div_wr(div_wr), .div_val(div_val), .div_active(div_active),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
        .cmd_tms(cmd_tms), .cmd_tdi(cmd_tdi),
        .rsp_done(rsp_done), .rsp_tdo(rsp_tdo),
        .tck_o(tck_o), .tck_oe(tck_oe), .tms_o(tms_o), .tms_oe(tms_oe),
        .tdi_o(tdi_o), .tdi_oe(tdi_oe), .tdo_i(tdo_i)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int len);
        return (len > MAXB) ? MAXB : len;
    endfunction

    function automatic logic [63:0] exp_rsp(input logic [31:0] pat, input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return {32'd0, pat} & m;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic write_div(input int v);
        div_wr  = 1'b1;
        div_val = DW'(v);
        @(negedge clk);
        div_wr  = 1'b0;
        @(negedge clk);
    endtask

    // Issue a command and judge it bit by bit; optionally write a divisor in the accept cycle.
    task automatic run_cmd(input int len, input logic [31:0] tms, input logic [31:0] tdi,
                           input logic [31:0] tdop, input int div,
                           input bit with_wr, input int new_div);
        int n, cyc, rises, limit;
        bit prev, bits_ok, done_seen;
        n = eff_len(len);
        limit = 2 * n * div + 8;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_len   = LW'(len);
        cmd_tms   = tms;
        cmd_tdi   = tdi;
        tdo_i     = tdop[0];
        if (with_wr) begin
            div_wr  = 1'b1;
            div_val = DW'(new_div);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        div_wr    = 1'b0;
        cyc = 0; rises = 0; prev = 1'b0; bits_ok = 1'b1; done_seen = 1'b0;
        if (n > 0) chk(!cmd_ready, "R9 ready low while busy", cmd_ready, 0);
        while (1) begin
            if (tck_o && !prev) begin
                if (rises >= n || cyc != (2 * rises + 1) * div) begin
                    bits_ok = 1'b0;
                    chk(0, "R1 rising edge position", cyc, (2 * rises + 1) * div);
                end else if (tms_o !== tms[rises] || tdi_o !== tdi[rises]) begin
                    bits_ok = 1'b0;
                    chk(0, "R4 tms/tdi at rise", {tms_o, tdi_o}, {tms[rises], tdi[rises]});
                end
                rises++;
            end
            if (!tck_o && prev && rises < n && rises < 32) tdo_i = tdop[rises];
            if (rsp_done) begin
                done_seen = 1'b1;
                break;
            end
            if (cyc > limit) break;
            prev = tck_o;
            @(negedge clk);
            cyc++;
        end
        chk(bits_ok, "R1 R4 edge timing and line values", bits_ok, 1);
        chk(done_seen && cyc == 2 * n * div, "R6 done timing", cyc, 2 * n * div);
        chk(rises == n, "R6 rising edge count", rises, n);
        chk(!tck_o, "R1 tck low at done", tck_o, 0);
        chk({32'd0, rsp_tdo} == exp_rsp(tdop, n), "R5 captured word", rsp_tdo, exp_rsp(tdop, n));
        @(negedge clk);
        chk(!rsp_done, "R6 done lasts one cycle", rsp_done, 0);
        chk({32'd0, rsp_tdo} == exp_rsp(tdop, n), "R6 result held", rsp_tdo, exp_rsp(tdop, n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int seen;
        void'($urandom(32'd7311));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(!tck_o, "R1 tck low after reset", tck_o, 0);
        chk(!tck_oe && !tms_oe && !tdi_oe, "R10 enables low after reset", {tck_oe, tms_oe, tdi_oe}, 0);
        chk(div_active == 4, "R2 reset divisor", div_active, 4);
        chk(!cmd_ready, "R9 not ready while disabled", cmd_ready, 0);

        enable = 1'b1;
        @(negedge clk);
        chk(tck_oe && tms_oe && tdi_oe, "R10 enables follow enable", {tck_oe, tms_oe, tdi_oe}, 7);
        chk(cmd_ready, "R9 ready when idle and enabled", cmd_ready, 1);

        // Divisor filtering
        write_div(0);
        chk(div_active == 4, "R2 zero divisor ignored", div_active, 4);
        write_div(DMAX + 1);
        chk(div_active == 4, "R2 oversize divisor ignored", div_active, 4);
        write_div(4095);
        chk(div_active == 4, "R2 all-ones divisor ignored", div_active, 4);
        write_div(1);
        chk(div_active == 1, "R2 divisor of one taken", div_active, 1);

        // Fastest clock, directed patterns
        run_cmd(8, 32'hA5, 32'h3C, 32'h96, 1, 0, 0);
        run_cmd(1, 32'h1, 32'h0, 32'h1, 1, 0, 0);
        // R7 zero length
        run_cmd(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0);
        // R8 overlong length clamps to the full width
        run_cmd(40, 32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 1, 0, 0);
        run_cmd(32, 32'h8000_0001, 32'h7FFF_FFFE, 32'hF0F0_0F0F, 1, 0, 0);

        // R3 divisor write coinciding with acceptance
        write_div(3);
        run_cmd(5, 32'h15, 32'h0A, 32'h1B, 3, 1, 2);
        chk(div_active == 2, "R3 same-cycle write taken", div_active, 2);
        run_cmd(6, 32'h2A, 32'h33, 32'h2D, 2, 0, 0);

        // Slowest divisor
        write_div(DMAX);
        chk(div_active == DMAX, "R2 maximum divisor taken", div_active, DMAX);
        run_cmd(2, 32'h2, 32'h1, 32'h3, DMAX, 0, 0);

        // R10 abort by dropping enable
        write_div(3);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_len = LW'(10); cmd_tms = 32'h3FF; cmd_tdi = 32'h155;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!tck_o && !tck_oe && !tms_oe && !tdi_oe, "R10 release on disable",
            {tck_o, tck_oe, tms_oe, tdi_oe}, 0);
        seen = 0;
        repeat (80) begin
            if (rsp_done || tck_o) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R10 abandoned command silent", seen, 0);
        enable = 1'b1;
        @(negedge clk);
        run_cmd(3, 32'h5, 32'h2, 32'h6, 3, 0, 0);

        // Random commands
        for (int i = 0; i < 24; i++) begin
            int d, l;
            d = $urandom_range(1, 6);
            l = $urandom_range(0, MAXB);
            write_div(d);
            run_cmd(l, $urandom(), $urandom(), $urandom(), d, 0, 0);
        end
        finish_run();
    end
endmodule